// File: doc/BRIEF.md
# Serial Register Access Frame Engine

This block is a bit-serial management slave that lets a host processor read and write the registers of a chip. The host shifts a fixed seven-octet command frame into the block. The block checks that the frame is addressed to this device type and this chip, that the opcode is legal, and that the XOR checksum is right. It then makes exactly one access on a simple synchronous register port, using an address octet and an array index octet. After that it shifts out a fixed six-octet response frame that carries a result code and, for reads, the register value.

The chip identity comes from two strap pins that are captured while reset is asserted. A frame that fails any check is dropped. A dropped frame causes no register access and no response. The register port reports access violations through a flag. Such accesses return a result code of 1.

Top module: `sra_engine`

## Requirements
- R1: A bit is taken on a rising clock edge when `rx_sel` and `rx_en` are both high. Bits arrive least significant bit first within each octet. The command frame has seven octets in this order: command, address, index, data high, data middle, data low, checksum. Whenever `rx_sel` is low, a partly received frame is discarded and the next accepted bit starts a new frame.
- R2: The command octet is decoded as follows. Bits 7:5 must equal the parameter `DEV_TYPE` (default 001). Bit 4 must be 0. Bits 3:2 must equal the chip ID. Bits 1:0 select the operation: 01 is a read and 11 is a write. Any other opcode is illegal.
- R3: A frame is accepted only when the XOR of all seven octets is zero. This is the same as the checksum octet being equal to the XOR of the six octets before it.
- R4: A frame that fails R2 or R3 produces no `reg_req` pulse and no response.
- R5: An accepted write raises `reg_req` with `reg_wr`=1. It presents the address, the index and the 24-bit data, with the data high octet in bits 23:16.
- R6: An accepted read raises `reg_req` with `reg_wr`=0. The response data field carries `reg_rdata`, with narrower registers right-aligned at bit 0.
- R7: The response is six octets, sent least significant bit first within each octet, in this order: command, result, data high, data middle, data low, checksum. The command octet is 0x03 for a write and 0x01 for a read. The data field is zero for writes and for violations. The checksum is the XOR of the five octets before it. `tx_bit` is 0 whenever `tx_valid` is low.
- R8: If `reg_viol` is high in the cycle after `reg_req`, the result octet is 0x01. Otherwise it is 0x00.
- R9: Let edge E0 be the clock edge that takes the last bit of a frame. `reg_req` is high for exactly the one cycle between E1 and E2. `reg_rdata` and `reg_viol` are sampled between E2 and E3. `tx_valid` is high from E3 for exactly 48 cycles, and response bit k is shown after edge E3+k.
- R10: The chip ID is taken from `strap_id` only while `rst_n` is low. Later changes on `strap_id` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the chip ID is captured while this is low |
| strap_id | input | 2 | Chip ID strap pins |
| rx_sel | input | 1 | Frame select; low discards any partial frame |
| rx_en | input | 1 | Bit strobe for the serial input |
| rx_bit | input | 1 | Serial command data |
| tx_valid | output | 1 | High while a response bit is on `tx_bit` |
| tx_bit | output | 1 | Serial response data |
| reg_req | output | 1 | One-cycle register access strobe |
| reg_wr | output | 1 | 1 for a write, 0 for a read |
| reg_addr | output | 8 | Register number |
| reg_idx | output | 8 | Index within a register array |
| reg_wdata | output | 24 | Write data |
| reg_rdata | input | 24 | Read data, valid the cycle after `reg_req` |
| reg_viol | input | 1 | Access violation, valid the cycle after `reg_req` |

## Verification
Each result is checked on the cycle R9 gives for it. The bench counts falling edges from the one on which it drives the last frame bit. On the second falling edge it checks that `reg_req` is high and that the address, index, data and direction are correct. On the third it checks that `tx_valid` is still low. From the fourth it reads 48 response bits, one per falling edge, and then checks that `tx_valid` has dropped. For a dropped frame, the bench watches 60 falling edges and checks that neither `reg_req` nor `tx_valid` rises. The response octets are compared with values that the bench computes from its own shadow of the register bank.

// File: rtl/sra_pkg.sv
package sra_pkg;
  localparam int OCT_W      = 8;
  localparam int CMD_OCTETS = 7;
  localparam int RSP_OCTETS = 6;
  localparam int CMD_BITS   = CMD_OCTETS * OCT_W;
  localparam int RSP_BITS   = RSP_OCTETS * OCT_W;
  localparam int DATA_W     = 24;

  localparam logic [1:0] OP_RD = 2'b01;
  localparam logic [1:0] OP_WR = 2'b11;
  localparam logic [7:0] RSP_CMD_WR = 8'h03;
  localparam logic [7:0] RSP_CMD_RD = 8'h01;

  typedef struct packed {
    logic [2:0] dev_type;
    logic       rsvd;
    logic [1:0] chip_id;
    logic [1:0] op;
  } cmd_t;

  // XOR of all command octets; zero for an intact frame
  function automatic logic [7:0] fold_cmd(input logic [CMD_BITS-1:0] f);
    logic [7:0] x;
    x = '0;
    for (int i = 0; i < CMD_OCTETS; i++) x ^= f[i*OCT_W +: OCT_W];
    return x;
  endfunction

  // Response frame; octet 0 sits at bits 7:0 so it leaves first
  function automatic logic [RSP_BITS-1:0] build_rsp(input logic wr, input logic viol,
                                                   input logic [DATA_W-1:0] rd);
    logic [7:0] c, r, k;
    logic [DATA_W-1:0] d;
    c = wr ? RSP_CMD_WR : RSP_CMD_RD;
    r = {7'd0, viol};
    d = (wr || viol) ? '0 : rd;
    k = c ^ r ^ d[23:16] ^ d[15:8] ^ d[7:0];
    return {k, d[7:0], d[15:8], d[23:16], r, c};
  endfunction
endpackage

// File: rtl/sra_rx.sv
module sra_rx
  import sra_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_sel,
  input  logic                rx_en,
  input  logic                rx_bit,
  output logic [CMD_BITS-1:0] frame_q,
  output logic                frame_done
);
  localparam int CW = $clog2(CMD_BITS);
  logic [CW-1:0] cnt;
  wire last_bit = (cnt == CW'(CMD_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      frame_q    <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (!rx_sel) begin
        cnt <= '0;
      end else if (rx_en) begin
        frame_q[cnt] <= rx_bit;
        if (last_bit) begin
          cnt        <= '0;
          frame_done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sra_decode.sv
module sra_decode
  import sra_pkg::*;
#(
  parameter logic [2:0] DEV_TYPE = 3'b001
) (
  input  logic [CMD_BITS-1:0] frame,
  input  logic [1:0]          chip_id,
  output logic                frame_ok,
  output logic                is_write,
  output logic [7:0]          addr,
  output logic [7:0]          idx,
  output logic [DATA_W-1:0]   wdata
);
  cmd_t cmd;
  logic sum_ok, target_ok, op_ok;

  always_comb begin
    cmd       = cmd_t'(frame[7:0]);
    addr      = frame[15:8];
    idx       = frame[23:16];
    wdata     = {frame[31:24], frame[39:32], frame[47:40]};
    sum_ok    = (fold_cmd(frame) == 8'h00);
    target_ok = (cmd.dev_type == DEV_TYPE) && !cmd.rsvd && (cmd.chip_id == chip_id);
    op_ok     = (cmd.op == OP_RD) || (cmd.op == OP_WR);
    is_write  = (cmd.op == OP_WR);
    frame_ok  = sum_ok && target_ok && op_ok;
  end
endmodule

// File: rtl/sra_ctrl.sv
module sra_ctrl
  import sra_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_done,
  input  logic                frame_ok,
  input  logic                is_write,
  input  logic [7:0]          addr,
  input  logic [7:0]          idx,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W-1:0]   reg_rdata,
  input  logic                reg_viol,
  input  logic                tx_busy,
  output logic                reg_req,
  output logic                reg_wr,
  output logic [7:0]          reg_addr,
  output logic [7:0]          reg_idx,
  output logic [DATA_W-1:0]   reg_wdata,
  output logic                tx_load,
  output logic [RSP_BITS-1:0] tx_word
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_SEND} state_t;
  state_t state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      reg_wr    <= 1'b0;
      reg_addr  <= '0;
      reg_idx   <= '0;
      reg_wdata <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (frame_done && frame_ok) begin
          reg_wr    <= is_write;
          reg_addr  <= addr;
          reg_idx   <= idx;
          reg_wdata <= wdata;
          state     <= S_REQ;
        end
        S_REQ:  state <= S_WAIT;
        S_WAIT: state <= S_SEND;
        S_SEND: if (!tx_busy) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_req = (state == S_REQ);
    tx_load = (state == S_WAIT);
    tx_word = build_rsp(reg_wr, reg_viol, reg_rdata);
  end
endmodule

// File: rtl/sra_tx.sv
module sra_tx
  import sra_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [RSP_BITS-1:0] word,
  output logic                busy,
  output logic                bit_out
);
  localparam int CW = $clog2(RSP_BITS);
  logic [RSP_BITS-1:0] sh;
  logic [CW-1:0]       left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sh   <= word;
      left <= CW'(RSP_BITS - 1);
      busy <= 1'b1;
    end else if (busy) begin
      sh <= sh >> 1;
      if (left == '0) busy <= 1'b0;
      else            left <= left - 1'b1;
    end
  end

  assign bit_out = busy & sh[0];
endmodule

// File: rtl/sra_engine.sv
module sra_engine
  import sra_pkg::*;
#(
  parameter logic [2:0] DEV_TYPE = 3'b001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  strap_id,
  input  logic        rx_sel,
  input  logic        rx_en,
  input  logic        rx_bit,
  output logic        tx_valid,
  output logic        tx_bit,
  output logic        reg_req,
  output logic        reg_wr,
  output logic [7:0]  reg_addr,
  output logic [7:0]  reg_idx,
  output logic [23:0] reg_wdata,
  input  logic [23:0] reg_rdata,
  input  logic        reg_viol
);
  logic [1:0]          chip_id;
  logic [CMD_BITS-1:0] frame;
  logic                frame_done, frame_ok, is_write, tx_load;
  logic [7:0]          dec_addr, dec_idx;
  logic [DATA_W-1:0]   dec_wdata;
  logic [RSP_BITS-1:0] tx_word;

  // straps follow the pins only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) chip_id <= strap_id;
  end

  sra_rx u_rx (
    .clk, .rst_n, .rx_sel, .rx_en, .rx_bit,
    .frame_q(frame), .frame_done
  );

  sra_decode #(.DEV_TYPE(DEV_TYPE)) u_dec (
    .frame, .chip_id, .frame_ok, .is_write,
    .addr(dec_addr), .idx(dec_idx), .wdata(dec_wdata)
  );

  sra_ctrl u_ctrl (
    .clk, .rst_n, .frame_done, .frame_ok, .is_write,
    .addr(dec_addr), .idx(dec_idx), .wdata(dec_wdata),
    .reg_rdata, .reg_viol, .tx_busy(tx_valid),
    .reg_req, .reg_wr, .reg_addr, .reg_idx, .reg_wdata,
    .tx_load, .tx_word
  );

  sra_tx u_tx (
    .clk, .rst_n, .load(tx_load), .word(tx_word),
    .busy(tx_valid), .bit_out(tx_bit)
  );
endmodule

// File: rtl/sra_engine_checker.sv
module sra_engine_checker
  import sra_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic frame_done,
  input logic frame_ok,
  input logic reg_req,
  input logic tx_valid,
  input logic tx_bit
);
  logic [7:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_len <= '0;
    else if (tx_valid) run_len <= run_len + 1'b1;
    else               run_len <= '0;
  end

  assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |=> !reg_req);
  assert_req_needs_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_req) |-> $past(frame_done && frame_ok));
  assert_bad_frame_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_ok) |=> !reg_req);
  assert_rsp_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(reg_req, 2));
  assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |-> !tx_bit);
  assert_rsp_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_valid) |-> (run_len == 8'(RSP_BITS)));
  assert_rsp_no_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (run_len < 8'(RSP_BITS)));
endmodule

bind sra_engine sra_engine_checker u_chk (
  .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_ok(frame_ok),
  .reg_req(reg_req), .tx_valid(tx_valid), .tx_bit(tx_bit)
);

// File: tb/sra_engine_bench.sv
module sra_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] strap_id = 2'b10;
  logic rx_sel = 1'b0, rx_en = 1'b0, rx_bit = 1'b0;
  logic tx_valid, tx_bit, reg_req, reg_wr, reg_viol;
  logic [7:0] reg_addr, reg_idx;
  logic [23:0] reg_wdata, reg_rdata;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sra_engine u_sra_engine (
    .clk, .rst_n, .strap_id, .rx_sel, .rx_en, .rx_bit,
    .tx_valid, .tx_bit, .reg_req, .reg_wr, .reg_addr, .reg_idx,
    .reg_wdata, .reg_rdata, .reg_viol
  );

  // Stand-in bank: addresses 0..3, index 0..3. Address 2 is 8 bits wide; address 3 is read-only.
  logic [23:0] mem [16];
  logic [23:0] shadow [16];

  function automatic bit model_viol(input logic [7:0] a, input logic [7:0] i, input bit wr);
    return (a > 8'd3) || (i > 8'd3) || (wr && a == 8'd3);
  endfunction

  function automatic logic [23:0] ro_value(input logic [7:0] i);
    return 24'h5A0000 | {16'd0, i};
  endfunction

  always @(posedge clk) begin
    reg_viol  <= 1'b0;
    reg_rdata <= 24'd0;
    if (reg_req) begin
      if (model_viol(reg_addr, reg_idx, reg_wr)) reg_viol <= 1'b1;
      else if (reg_wr)
        mem[{reg_addr[1:0], reg_idx[1:0]}] <= (reg_addr == 8'd2) ? {16'd0, reg_wdata[7:0]} : reg_wdata;
      else if (reg_addr == 8'd3) reg_rdata <= ro_value(reg_idx);
      else reg_rdata <= mem[{reg_addr[1:0], reg_idx[1:0]}];
    end
  end

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [55:0] make_frame(input logic [7:0] c, input logic [7:0] a,
      input logic [7:0] i, input logic [23:0] d, input bit bad);
    logic [7:0] s;
    s = c ^ a ^ i ^ d[23:16] ^ d[15:8] ^ d[7:0] ^ (bad ? 8'h40 : 8'h00);
    return {s, d[7:0], d[15:8], d[23:16], i, a, c};
  endfunction

  task automatic shift_bits(input logic [55:0] f, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_sel = 1'b1; rx_en = 1'b1; rx_bit = f[k];
    end
  endtask

  task automatic run_frame(input logic [7:0] c, input logic [7:0] a, input logic [7:0] i,
      input logic [23:0] d, input bit bad, input bit want_rsp, input string tag);
    bit wr, vio;
    logic [23:0] rd, ed;
    logic [47:0] got;
    logic [7:0] rc, rr, rk;
    int seen;
    wr = (c[1:0] == 2'b11);
    vio = model_viol(a, i, wr);
    rd = (a == 8'd3) ? ro_value(i) : shadow[{a[1:0], i[1:0]}];
    shift_bits(make_frame(c, a, i, d, bad), 56);
    @(negedge clk); rx_en = 1'b0;
    if (!want_rsp) begin
      seen = 0;
      for (int k = 0; k < 60; k++) begin
        if (reg_req || tx_valid) seen++;
        @(negedge clk);
      end
      check({tag, " R4 dropped frame stays silent"}, 48'(seen), 48'd0);
      return;
    end
    @(negedge clk);
    check({tag, " R9 reg_req on second cycle"}, {47'd0, reg_req}, 48'd1);
    check({tag, " R5/R6 port fields"}, {15'd0, reg_wr, reg_addr, reg_idx, reg_wdata},
          {15'd0, wr, a, i, d});
    @(negedge clk);
    check({tag, " R9 no response before E3"}, {47'd0, tx_valid}, 48'd0);
    seen = 0;
    for (int k = 0; k < 48; k++) begin
      @(negedge clk);
      got[k] = tx_bit;
      if (tx_valid) seen++;
    end
    @(negedge clk);
    check({tag, " R9 tx_valid 48 cycles"}, {47'd0, tx_valid}, 48'd0);
    check({tag, " R9 tx_valid count"}, 48'(seen), 48'd48);
    rc = wr ? 8'h03 : 8'h01;
    rr = vio ? 8'h01 : 8'h00;
    ed = (wr || vio) ? 24'd0 : rd;
    rk = rc ^ rr ^ ed[23:16] ^ ed[15:8] ^ ed[7:0];
    check({tag, " R7/R8 response command and result"}, {32'd0, got[15:8], got[7:0]}, {32'd0, rr, rc});
    check({tag, " R6/R7 response data"}, {24'd0, got[23:16], got[31:24], got[39:32]}, {24'd0, ed});
    check({tag, " R7 response checksum"}, {40'd0, got[47:40]}, {40'd0, rk});
    if (wr && !vio) shadow[{a[1:0], i[1:0]}] = (a == 8'd2) ? {16'd0, d[7:0]} : d;
  endtask

  function automatic logic [7:0] cmd_of(input logic [2:0] t, input logic r4, input logic [1:0] id,
      input logic [1:0] op);
    return {t, r4, id, op};
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 16; k++) begin mem[k] = 24'd0; shadow[k] = 24'd0; end
    repeat (4) @(negedge clk);
    check("reset outputs R7/R9", {45'd0, tx_valid, tx_bit, reg_req}, 48'd0);
    rst_n = 1'b1;
    strap_id = 2'b01;  // R10: change after reset must be ignored
    @(negedge clk);

    // Directed cases
    run_frame(cmd_of(3'b001, 1'b0, 2'b10, 2'b11), 8'd0, 8'd1, 24'hABCDEF, 1'b0, 1'b1, "R5 write");
    run_frame(cmd_of(3'b001, 1'b0, 2'b10, 2'b01), 8'd0, 8'd1, 24'd0, 1'b0, 1'b1, "R6 read back");
    run_frame(cmd_of(3'b001, 1'b0, 2'b10, 2'b11), 8'd2, 8'd3, 24'h123456, 1'b0, 1'b1, "R6 narrow write");
    run_frame(cmd_of(3'b001, 1'b0, 2'b10, 2'b01), 8'd2, 8'd3, 24'd0, 1'b0, 1'b1, "R6 narrow read");
    run_frame(cmd_of(3'b001, 1'b0, 2'b10, 2'b11), 8'd3, 8'd0, 24'h777777, 1'b0, 1'b1, "R8 read-only write");
    run_frame(cmd_of(3'b001, 1'b0, 2'b10, 2'b01), 8'd3, 8'd2, 24'd0, 1'b0, 1'b1, "R6 read-only read");
    run_frame(cmd_of(3'b001, 1'b0, 2'b10, 2'b01), 8'd9, 8'd0, 24'd0, 1'b0, 1'b1, "R8 address out of range");
    run_frame(cmd_of(3'b001, 1'b0, 2'b10, 2'b11), 8'd1, 8'd7, 24'h1, 1'b0, 1'b1, "R8 index out of range");
    run_frame(cmd_of(3'b001, 1'b0, 2'b10, 2'b11), 8'd1, 8'd1, 24'h111, 1'b1, 1'b0, "R3 bad checksum");
    run_frame(cmd_of(3'b010, 1'b0, 2'b10, 2'b11), 8'd1, 8'd1, 24'h222, 1'b0, 1'b0, "R2 wrong type");
    run_frame(cmd_of(3'b001, 1'b1, 2'b10, 2'b11), 8'd1, 8'd1, 24'h333, 1'b0, 1'b0, "R2 bit4 set");
    run_frame(cmd_of(3'b001, 1'b0, 2'b10, 2'b00), 8'd1, 8'd1, 24'h444, 1'b0, 1'b0, "R2 opcode 00");
    run_frame(cmd_of(3'b001, 1'b0, 2'b10, 2'b10), 8'd1, 8'd1, 24'h555, 1'b0, 1'b0, "R2 opcode 10");
    run_frame(cmd_of(3'b001, 1'b0, 2'b01, 2'b11), 8'd1, 8'd1, 24'h666, 1'b0, 1'b0, "R10 new strap ignored");
    run_frame(cmd_of(3'b001, 1'b0, 2'b10, 2'b01), 8'd1, 8'd1, 24'd0, 1'b0, 1'b1, "R4 register untouched");

    // R1: a partial frame is thrown away when rx_sel drops
    shift_bits(make_frame(cmd_of(3'b001, 1'b0, 2'b10, 2'b11), 8'd0, 8'd0, 24'h999999, 1'b0), 20);
    @(negedge clk); rx_sel = 1'b0; rx_en = 1'b0;
    run_frame(cmd_of(3'b001, 1'b0, 2'b10, 2'b11), 8'd0, 8'd2, 24'h0F0F0F, 1'b0, 1'b1, "R1 restart after deselect");
    run_frame(cmd_of(3'b001, 1'b0, 2'b10, 2'b01), 8'd0, 8'd0, 24'd0, 1'b0, 1'b1, "R1 partial frame not written");

    // Random traffic
    for (int n = 0; n < 40; n++) begin
      logic [7:0] a, i;
      logic [23:0] d;
      bit w;
      a = 8'($urandom_range(0, 5));
      i = 8'($urandom_range(0, 4));
      d = 24'($urandom);
      w = 1'($urandom_range(0, 1));
      run_frame(cmd_of(3'b001, 1'b0, 2'b10, w ? 2'b11 : 2'b01), a, i, w ? d : 24'd0,
                1'b0, 1'b1, "R5/R6 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule